// File: doc/BRIEF.md
# Ethernet Status LED Driver with Strap-Selected Polarity

This block drives the two status LEDs of an Ethernet port: a link LED and a speed LED. Each LED pin has two roles. While reset is held, the pin is not driven and acts as a configuration strap input. A pull resistor on the board sets its level. When reset is released, the block latches that level, and the latched bit sets the drive polarity of that pin for the rest of the session. A strap level of 0 gives an active-high LED and a level of 1 gives an active-low LED.

After reset, the link LED is lit while the link is up. It goes dark for a short time whenever carrier sense rises, which is the activity blink. The speed LED shows the 100 Mbit versus 10 Mbit rate. A pulse stretcher sets the blink length to a fixed number of clock cycles (`ACT_CYCLES`), and a new carrier edge during a blink restarts it. If the wrong strap value is captured, both LED senses invert, so the latched polarity bits appear on a status output for inspection.

The pins are given as separate input, output and output-enable vectors. Index 0 is the link LED and index 1 is the speed LED. The pad and its pull resistor are outside the block.

Top module: `eth_led_drv`

## Requirements
- R1: `pol_state[i]` equals the level of `led_i[i]` at the last rising clock edge before `rst_n` goes high (index 0 = link, index 1 = speed).
- R2: While `rst_n` is low, `led_oe` is 2'b00 and `led_o` is 2'b00.
- R3: From the first rising clock edge with `rst_n` high, `led_oe` is 2'b11.
- R4: After reset, `pol_state` does not change until the next reset, whatever `led_i` does.
- R5: The driven level is `led_o[i] = lit[i] ^ pol_state[i]`, so polarity bit 0 means the pin is high when the LED is lit, and 1 means it is low when lit.
- R6: The link LED is lit exactly when `link_up` is 1 and no activity blink is in progress. With no link it is dark.
- R7: The speed LED is lit exactly when `speed_100` is 1, and the activity blink does not affect it.
- R8: A rising edge of `crs` (sampled 0 at one clock edge and 1 at the next) darkens the link LED for exactly `ACT_CYCLES` cycles, starting right after the edge where it was sampled high.
- R9: A new `crs` rising edge during a blink restarts the full `ACT_CYCLES` interval.
- R10: Holding `crs` high does not lengthen a blink; the link LED returns to lit after `ACT_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; while low, the LED pins act as strap inputs |
| link_up | input | 1 | Link is established |
| speed_100 | input | 1 | 1 = 100 Mbit, 0 = 10 Mbit |
| crs | input | 1 | Carrier sense |
| led_i | input | 2 | Pad input levels (strap values during reset) |
| led_o | output | 2 | Pad output levels |
| led_oe | output | 2 | Pad output enables |
| pol_state | output | 2 | Latched polarity bits, 1 = active-low |

## Verification
The assertions check these rules on every cycle: the pins are tri-stated during reset and enabled after it, the polarity is latched from the pin levels at the release edge and then holds steady, the speed pin follows its input through the polarity, the link LED is dark without a link, and it goes dark right after a carrier edge. Only the bench scenarios can show the exact length of the blink, its restart by a later edge, the end of the blink while carrier stays high, and the result under all four strap combinations.

// File: rtl/eld_pkg.sv
package eld_pkg;
  localparam int unsigned NUM_LEDS  = 2;
  localparam int unsigned IDX_LINK  = 0;
  localparam int unsigned IDX_SPEED = 1;
  typedef logic [NUM_LEDS-1:0] led_vec_t;
endpackage

// File: rtl/eld_strap_latch.sv
// Tracks the pad levels while reset is held; freezes them on release.
module eld_strap_latch
  import eld_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  led_vec_t pad_in,
  output led_vec_t strap_q
);
  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) strap_q[g] <= pad_in[g];
    end
  end
endmodule

// File: rtl/eld_act_stretch.sv
// Turns each carrier-sense rising edge into a fixed-length blink window.
module eld_act_stretch #(
  parameter int unsigned ACT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crs,
  output logic blink
);
  localparam int unsigned CW = $clog2(ACT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(ACT_CYCLES);

  logic          crs_q;
  logic [CW-1:0] cnt;
  logic          crs_edge;

  always_ff @(posedge clk) crs_q <= crs;

  assign crs_edge = crs & ~crs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (crs_edge)     cnt <= LOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign blink = (cnt != '0);
endmodule

// File: rtl/eld_pol_drive.sv
// Applies per-pin polarity and the output enable to the logical LED states.
module eld_pol_drive
  import eld_pkg::*;
(
  input  led_vec_t lit,
  input  led_vec_t pol,
  input  logic     drive_en,
  output led_vec_t pad_out,
  output led_vec_t pad_oe
);
  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_pin
    assign pad_out[g] = drive_en & (lit[g] ^ pol[g]);
    assign pad_oe[g]  = drive_en;
  end
endmodule

// File: rtl/eth_led_drv.sv
module eth_led_drv
  import eld_pkg::*;
#(
  parameter int unsigned ACT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up,
  input  logic       speed_100,
  input  logic       crs,
  input  logic [1:0] led_i,
  output logic [1:0] led_o,
  output logic [1:0] led_oe,
  output logic [1:0] pol_state
);
  led_vec_t strap_q;
  led_vec_t lit;
  logic     blink;
  logic     drive_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_en <= 1'b0;
    else        drive_en <= 1'b1;
  end

  eld_strap_latch u_strap (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_in  (led_i),
    .strap_q (strap_q)
  );

  eld_act_stretch #(.ACT_CYCLES(ACT_CYCLES)) u_act (
    .clk   (clk),
    .rst_n (rst_n),
    .crs   (crs),
    .blink (blink)
  );

  always_comb begin
    lit            = '0;
    lit[IDX_LINK]  = link_up & ~blink;
    lit[IDX_SPEED] = speed_100;
  end

  eld_pol_drive u_drv (
    .lit      (lit),
    .pol      (strap_q),
    .drive_en (drive_en),
    .pad_out  (led_o),
    .pad_oe   (led_oe)
  );

  assign pol_state = strap_q;
endmodule

// File: rtl/eth_led_drv_chk.sv
module eth_led_drv_chk #(
  parameter int unsigned ACT_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       link_up,
  input logic       speed_100,
  input logic       crs,
  input logic [1:0] led_i,
  input logic [1:0] led_o,
  input logic [1:0] led_oe,
  input logic [1:0] pol_state
);
  // R2
  a_r2_tristate_in_reset: assert property (@(posedge clk)
    !rst_n |-> (led_oe == 2'b00 && led_o == 2'b00));

  // R3
  a_r3_enable_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (led_oe == 2'b11));

  // R1
  a_r1_strap_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pol_state == $past(led_i)));

  // R4
  a_r4_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(pol_state));

  // R6
  a_r6_dark_without_link: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && led_oe[0]) |-> ((led_o[0] ^ pol_state[0]) == 1'b0));

  // R7
  a_r7_speed_follows: assert property (@(posedge clk) disable iff (!rst_n)
    led_oe[1] |-> ((led_o[1] ^ pol_state[1]) == speed_100));

  // R8
  a_r8_blink_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (ACT_CYCLES > 0 && $rose(crs)) |=> ((led_o[0] ^ pol_state[0]) == 1'b0));
endmodule

bind eth_led_drv eth_led_drv_chk #(.ACT_CYCLES(ACT_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .link_up   (link_up),
  .speed_100 (speed_100),
  .crs       (crs),
  .led_i     (led_i),
  .led_o     (led_o),
  .led_oe    (led_oe),
  .pol_state (pol_state)
);

// File: tb/eth_led_drv_bench.sv
module eth_led_drv_bench;
  localparam int CLK_P = 10;
  localparam int ACT   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_up = 1'b0;
  logic       speed_100 = 1'b0;
  logic       crs = 1'b0;
  logic [1:0] led_i = 2'b00;
  logic [1:0] led_o, led_oe, pol_state;

  int n_vec = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  eth_led_drv #(.ACT_CYCLES(ACT)) u_eth_led_drv (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .speed_100(speed_100),
    .crs(crs), .led_i(led_i), .led_o(led_o), .led_oe(led_oe),
    .pol_state(pol_state)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // expected pin levels: lit XOR strap polarity
  function automatic logic [1:0] pins(input logic lk, input logic sp, input logic [1:0] s);
    return {sp ^ s[1], lk ^ s[0]};
  endfunction

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      rst_n = 1'b0; link_up = 1'b0; speed_100 = 1'b0; crs = 1'b0;
      led_i = 2'(s);
      cyc(1);
      chk("R2", led_oe, 2'b00);
      chk("R2", led_o, 2'b00);
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      chk("R3", led_oe, 2'b11);
      chk("R1", pol_state, 2'(s));
      led_i = ~2'(s);   // strap pins move after release: must be ignored
      cyc(2);
      chk("R4", pol_state, 2'(s));
      for (int c = 0; c < 4; c++) begin
        link_up = c[0]; speed_100 = c[1];
        cyc(1);
        chk("R5 R6 R7", led_o, pins(c[0], c[1], 2'(s)));
      end
      // single blink, crs held high afterwards (R8, R10)
      link_up = 1'b1; speed_100 = s[0];
      cyc(1);
      crs = 1'b1;
      for (int k = 0; k < ACT; k++) begin
        cyc(1);
        chk("R8", led_o, pins(1'b0, s[0], 2'(s)));
      end
      cyc(1);
      chk("R10", led_o, pins(1'b1, s[0], 2'(s)));
      cyc(3);
      chk("R10", led_o, pins(1'b1, s[0], 2'(s)));
      // restart: second edge two cycles into a blink (R9)
      crs = 1'b0;
      cyc(2);
      crs = 1'b1;
      cyc(1);
      chk("R8", led_o, pins(1'b0, s[0], 2'(s)));
      crs = 1'b0;
      cyc(1);
      crs = 1'b1;
      for (int k = 0; k < ACT; k++) begin
        cyc(1);
        chk("R9", led_o, pins(1'b0, s[0], 2'(s)));
      end
      cyc(1);
      chk("R9", led_o, pins(1'b1, s[0], 2'(s)));
      // blink with no link stays dark afterwards
      crs = 1'b0; link_up = 1'b0;
      cyc(1);
      crs = 1'b1;
      cyc(ACT + 1);
      chk("R6", led_o, pins(1'b0, s[0], 2'(s)));
      // reset again: pins tri-stated
      rst_n = 1'b0;
      cyc(1);
      chk("R2", led_oe, 2'b00);
    end
    done = 1'b1;
  end

  initial begin
    int t = 0;
    while (!done && t < 20000) begin
      @(posedge clk);
      t++;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule